// File: doc/BRIEF.md
# Slot phase fit and discontinuity

This block follows a stream of unwrapped carrier-phase samples, one per chip, and splits it into contiguous measurement intervals of either a full slot (2560 chips) or a half slot (1280 chips). Within each interval it fits a least-squares straight line to the phase. The fit leaves out a 96-chip guard at both interval edges, where power-step transients are expected. The fitted line is then extrapolated to the interval's start edge (chip 0) and its end edge (chip L, the first chip of the next interval).

For every interval the block reports the fitted slope as the frequency error. It also reports the start phase relative to the first interval of the run, and the jump between this interval's extrapolated start phase and the previous interval's extrapolated end phase. A run is armed by raising the enable. Its first interval begins at the first accepted sample that carries the boundary strobe, and later intervals follow back to back, counted in accepted samples. The fit has no runtime divider: slope and mean come from multiplications by reciprocal constants fixed at elaboration for each interval length.

Phase is a signed integer in which 4096 LSB make one turn. The phase results are wrapped into that turn.

Top module: `slot_phase_fit`

## Requirements
- R1: After reset, res_vld and disc_vld are 0 and freq_err, rel_phase and disc_phase are 0.
- R2: While meas_en is high, a run begins at the first sample with smp_vld=1 and slot_strb=1. Samples before it are ignored. Later strobes are ignored and do not shift the interval boundaries. Only samples with smp_vld=1 advance the chip position.
- R3: half_mode is taken at the first sample of each interval and holds for that interval: 1 selects 1280 chips and 0 selects 2560 chips. A change of half_mode during an interval has no effect on it.
- R4: The fit uses chips 96 to L-97 of the interval only. Sample values at chips 0 to 95 and L-96 to L-1 have no effect on any result.
- R5: freq_err is the fitted slope in phase LSB per chip, signed, with 16 fractional bits. For an exact line it is within ±64 of slope·65536.
- R6: rel_phase is the extrapolated start phase (chip 0) minus that of the run's first interval, rounded and wrapped to a 12-bit two's-complement value (−2048..2047, 4096 LSB per turn), within ±2 LSB. For the first interval it is 0.
- R7: disc_phase is the extrapolated start phase of the interval minus the extrapolated phase of the previous interval at its chip L. It is rounded and wrapped as in R6, within ±2 LSB.
- R8: The first interval of a run gives res_vld with disc_vld=0 and disc_phase=0. Every later interval gives res_vld with disc_vld=1.
- R9: res_vld and disc_vld are one-cycle pulses. They are high after the third rising edge that follows the edge accepting chip L-97 of the interval. The data outputs hold their values between pulses.
- R10: While meas_en is low the block accepts no samples and produces no results. A later run begins with a fresh reference interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_en | input | 1 | Arms a run while high; low clears the run |
| half_mode | input | 1 | Interval length select: 1 half slot, 0 full slot |
| smp_vld | input | 1 | phase_in carries a chip sample this cycle |
| slot_strb | input | 1 | Marks a sample as the first chip of an interval |
| phase_in | input | YW (20) | Unwrapped phase, signed, 4096 LSB per turn |
| res_vld | output | 1 | Result pulse for one interval |
| disc_vld | output | 1 | disc_phase is meaningful with this pulse |
| freq_err | output | FREQ_W (38) | Fitted slope, LSB per chip, 16 fractional bits |
| rel_phase | output | TW (12) | Start phase relative to the reference interval, wrapped |
| disc_phase | output | TW (12) | Boundary phase jump, wrapped |

## Verification
Each interval's results are due at a fixed edge: the third rising edge after the one that accepts chip L-97. The 96-chip tail of the interval and any gaps in smp_vld do not move that edge. The bench records the edge index at which it drives each interval's last fit sample, and stamps every result pulse with the edge count seen at the following falling edge. A result counts as on time only if the stamp is exactly three edges later. The bench also checks that the number of pulses equals the number of intervals driven, including zero pulses while the block is disabled.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} sps_state_e;

  // Number of samples inside the fit window of an interval.
  function automatic int unsigned fit_count(input int unsigned len, input int unsigned guard);
    return len - 2 * guard;
  endfunction

  // round(2^sh / n): turns a sum of n samples into a mean.
  function automatic longint unsigned mean_recip(input longint unsigned n, input int unsigned sh);
    return ((64'd1 << sh) + (n >> 1)) / n;
  endfunction

  // round(6 * 2^sh / (n*(n^2-1))): turns sum(x2*y) into the slope,
  // with x2 = 2*k - (L-1), i.e. odd-valued centred positions.
  function automatic longint unsigned slope_recip(input longint unsigned n, input int unsigned sh);
    longint unsigned den;
    den = n * (n * n - 64'd1);
    return ((64'd6 << sh) + (den >> 1)) / den;
  endfunction

endpackage

// File: rtl/sps_pos_ctr.sv
module sps_pos_ctr
  import sps_pkg::*;
#(
  parameter int FULL_LEN = 2560,
  parameter int HALF_LEN = 1280,
  parameter int GUARD    = 96,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_en,
  input  logic             half_mode,
  input  logic             smp_vld,
  input  logic             slot_strb,
  output logic [CNT_W-1:0] pos_now,
  output logic             half_now,
  output logic             first_smp,
  output logic             in_fit,
  output logic             fit_last,
  output logic             fit_half
);

  localparam logic [CNT_W-1:0] F_LAST = CNT_W'(FULL_LEN - 1);
  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(HALF_LEN - 1);
  localparam logic [CNT_W-1:0] F_FEND = CNT_W'(FULL_LEN - GUARD - 1);
  localparam logic [CNT_W-1:0] H_FEND = CNT_W'(HALF_LEN - GUARD - 1);
  localparam logic [CNT_W-1:0] G_LO   = CNT_W'(GUARD);

  sps_state_e       state;
  logic [CNT_W-1:0] pos;
  logic             cur_half;
  logic             start_now;
  logic             take;
  logic             fit_end;
  logic [CNT_W-1:0] last_pos;
  logic [CNT_W-1:0] fend_pos;

  always_comb begin
    start_now = meas_en && smp_vld && slot_strb && (state == ST_WAIT);
    take      = meas_en && smp_vld && ((state == ST_RUN) || start_now);
    pos_now   = start_now ? '0 : pos;
    half_now  = (pos_now == '0) ? half_mode : cur_half;
    last_pos  = half_now ? H_LAST : F_LAST;
    fend_pos  = half_now ? H_FEND : F_FEND;
    first_smp = take && (pos_now == '0);
    in_fit    = take && (pos_now >= G_LO) && (pos_now <= fend_pos);
    fit_end   = take && (pos_now == fend_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pos      <= '0;
      cur_half <= 1'b0;
      fit_last <= 1'b0;
      fit_half <= 1'b0;
    end else begin
      fit_last <= fit_end;
      if (fit_end) fit_half <= half_now;
      if (!meas_en) begin
        state <= ST_IDLE;
        pos   <= '0;
      end else begin
        if (state == ST_IDLE) state <= ST_WAIT;
        if (start_now)        state <= ST_RUN;
        if (take) begin
          pos <= (pos_now == last_pos) ? '0 : pos_now + CNT_W'(1);
          if (pos_now == '0) cur_half <= half_mode;
        end
      end
    end
  end

  // R3: the position never leaves the current interval
  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (pos <= (cur_half ? H_LAST : F_LAST)));

  // R10: a disabled block finishes no fit
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> !fit_last);

endmodule

// File: rtl/sps_fit_accum.sv
module sps_fit_accum #(
  parameter int YW       = 20,
  parameter int CNT_W    = 12,
  parameter int FULL_LEN = 2560,
  parameter int HALF_LEN = 1280,
  parameter int SY_W     = 32,
  parameter int SXY_W    = 46
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    acc_en,
  input  logic [CNT_W-1:0]        pos,
  input  logic                    half,
  input  logic signed [YW-1:0]    phase,
  output logic signed [SY_W-1:0]  sum_y,
  output logic signed [SXY_W-1:0] sum_xy
);

  localparam logic signed [CNT_W+1:0] F_M1 = (CNT_W+2)'(FULL_LEN - 1);
  localparam logic signed [CNT_W+1:0] H_M1 = (CNT_W+2)'(HALF_LEN - 1);

  // centred position in half-chip units: odd values, symmetric about zero
  logic signed [CNT_W+1:0] xc;
  logic signed [SXY_W-1:0] xy;

  assign xc = $signed({1'b0, pos, 1'b0}) - (half ? H_M1 : F_M1);
  assign xy = SXY_W'(xc) * SXY_W'(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_y  <= '0;
      sum_xy <= '0;
    end else if (clr) begin
      sum_y  <= '0;
      sum_xy <= '0;
    end else if (acc_en) begin
      sum_y  <= sum_y + SY_W'(phase);
      sum_xy <= sum_xy + xy;
    end
  end

  // R4: samples outside the fit window leave the sums untouched
  assert_guard_no_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !clr) |=> ($stable(sum_y) && $stable(sum_xy)));

endmodule

// File: rtl/sps_line_solve.sv
module sps_line_solve
  import sps_pkg::*;
#(
  parameter int FULL_LEN = 2560,
  parameter int HALF_LEN = 1280,
  parameter int GUARD    = 96,
  parameter int SY_W     = 32,
  parameter int SXY_W    = 46,
  parameter int A_W      = 30,
  parameter int B_W      = 38,
  parameter int S_W      = 52,
  parameter int AF       = 8,
  parameter int BF       = 16,
  parameter int MSH      = 32,
  parameter int SSH      = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic                    half,
  input  logic signed [SY_W-1:0]  sum_y,
  input  logic signed [SXY_W-1:0] sum_xy,
  output logic                    vld,
  output logic signed [S_W-1:0]   start_q,
  output logic signed [S_W-1:0]   end_q,
  output logic signed [B_W-1:0]   slope_q
);

  localparam int unsigned N_F = fit_count(FULL_LEN, GUARD);
  localparam int unsigned N_H = fit_count(HALF_LEN, GUARD);
  localparam int MP_W = SY_W + MSH + 1;
  localparam int BP_W = SXY_W + SSH + 1;
  localparam logic signed [MP_W-1:0] RN_F = MP_W'(mean_recip(N_F, MSH));
  localparam logic signed [MP_W-1:0] RN_H = MP_W'(mean_recip(N_H, MSH));
  localparam logic signed [BP_W-1:0] RB_F = BP_W'(slope_recip(N_F, SSH));
  localparam logic signed [BP_W-1:0] RB_H = BP_W'(slope_recip(N_H, SSH));
  localparam logic signed [S_W-1:0]  FL_M1 = S_W'(FULL_LEN - 1);
  localparam logic signed [S_W-1:0]  FL_P1 = S_W'(FULL_LEN + 1);
  localparam logic signed [S_W-1:0]  HL_M1 = S_W'(HALF_LEN - 1);
  localparam logic signed [S_W-1:0]  HL_P1 = S_W'(HALF_LEN + 1);

  logic signed [MP_W-1:0] prod_a;
  logic signed [BP_W-1:0] prod_b;
  logic signed [A_W-1:0]  a_q;
  logic signed [B_W-1:0]  b_q;
  logic                   v1;
  logic                   h1;
  logic signed [S_W-1:0]  lm1, lp1, run_lo, run_hi;

  // stage 1: mean (AF fraction bits) at the window centre, slope (BF bits)
  assign prod_a = MP_W'(sum_y) * (half ? RN_H : RN_F);
  assign prod_b = BP_W'(sum_xy) * (half ? RB_H : RB_F);

  // stage 2: centre sits at (L-1)/2, edges at 0 and L
  assign lm1    = h1 ? HL_M1 : FL_M1;
  assign lp1    = h1 ? HL_P1 : FL_P1;
  assign run_lo = (S_W'(b_q) * lm1) >>> (BF - AF + 1);
  assign run_hi = (S_W'(b_q) * lp1) >>> (BF - AF + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      h1      <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      vld     <= 1'b0;
      start_q <= '0;
      end_q   <= '0;
      slope_q <= '0;
    end else begin
      v1  <= go;
      vld <= v1;
      if (go) begin
        h1  <= half;
        a_q <= A_W'(prod_a >>> (MSH - AF));
        b_q <= B_W'(prod_b >>> (SSH - BF));
      end
      if (v1) begin
        start_q <= S_W'(a_q) - run_lo;
        end_q   <= S_W'(a_q) + run_hi;
        slope_q <= b_q;
      end
    end
  end

endmodule

// File: rtl/slot_phase_fit.sv
module slot_phase_fit #(
  parameter int YW       = 20,
  parameter int TW       = 12,
  parameter int FULL_LEN = 2560,
  parameter int HALF_LEN = 1280,
  parameter int GUARD    = 96,
  parameter int AF       = 8,
  parameter int BF       = 16,
  parameter int MSH      = 32,
  parameter int SSH      = 48,
  parameter int FREQ_W   = YW + BF + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     meas_en,
  input  logic                     half_mode,
  input  logic                     smp_vld,
  input  logic                     slot_strb,
  input  logic signed [YW-1:0]     phase_in,
  output logic                     res_vld,
  output logic                     disc_vld,
  output logic signed [FREQ_W-1:0] freq_err,
  output logic signed [TW-1:0]     rel_phase,
  output logic signed [TW-1:0]     disc_phase
);

  localparam int CNT_W = $clog2(FULL_LEN);
  localparam int SY_W  = YW + CNT_W;
  localparam int SXY_W = YW + 2 * CNT_W + 2;
  localparam int A_W   = YW + AF + 2;
  localparam int B_W   = FREQ_W;
  localparam int S_W   = B_W + CNT_W + 2;

  logic [CNT_W-1:0]        pos_now;
  logic                    half_now, first_smp, in_fit, fit_last, fit_half;
  logic signed [SY_W-1:0]  sum_y;
  logic signed [SXY_W-1:0] sum_xy;
  logic                    fit_vld;
  logic signed [S_W-1:0]   start_q, end_q;
  logic signed [B_W-1:0]   slope_q;
  logic                    res_load;
  logic                    have_ref;
  logic signed [S_W-1:0]   ref_start, prev_end;

  // Round an AF-fraction phase to whole LSB and keep one turn.
  function automatic logic signed [TW-1:0] turn_wrap(input logic signed [S_W-1:0] v);
    logic signed [S_W-1:0] r;
    r = (v + S_W'(1 << (AF - 1))) >>> AF;
    return r[TW-1:0];
  endfunction

  sps_pos_ctr #(
    .FULL_LEN(FULL_LEN), .HALF_LEN(HALF_LEN), .GUARD(GUARD), .CNT_W(CNT_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .half_mode(half_mode),
    .smp_vld(smp_vld), .slot_strb(slot_strb), .pos_now(pos_now),
    .half_now(half_now), .first_smp(first_smp), .in_fit(in_fit),
    .fit_last(fit_last), .fit_half(fit_half)
  );

  sps_fit_accum #(
    .YW(YW), .CNT_W(CNT_W), .FULL_LEN(FULL_LEN), .HALF_LEN(HALF_LEN),
    .SY_W(SY_W), .SXY_W(SXY_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(first_smp), .acc_en(in_fit),
    .pos(pos_now), .half(half_now), .phase(phase_in),
    .sum_y(sum_y), .sum_xy(sum_xy)
  );

  sps_line_solve #(
    .FULL_LEN(FULL_LEN), .HALF_LEN(HALF_LEN), .GUARD(GUARD), .SY_W(SY_W),
    .SXY_W(SXY_W), .A_W(A_W), .B_W(B_W), .S_W(S_W), .AF(AF), .BF(BF),
    .MSH(MSH), .SSH(SSH)
  ) u_solve (
    .clk(clk), .rst_n(rst_n), .go(fit_last), .half(fit_half),
    .sum_y(sum_y), .sum_xy(sum_xy), .vld(fit_vld),
    .start_q(start_q), .end_q(end_q), .slope_q(slope_q)
  );

  assign res_load = fit_vld && meas_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      disc_vld   <= 1'b0;
      freq_err   <= '0;
      rel_phase  <= '0;
      disc_phase <= '0;
      have_ref   <= 1'b0;
      ref_start  <= '0;
      prev_end   <= '0;
    end else begin
      res_vld  <= res_load;
      disc_vld <= res_load && have_ref;
      if (!meas_en) begin
        have_ref <= 1'b0;
      end else if (res_load) begin
        freq_err <= slope_q;
        prev_end <= end_q;
        if (!have_ref) begin
          have_ref   <= 1'b1;
          ref_start  <= start_q;
          rel_phase  <= '0;
          disc_phase <= '0;
        end else begin
          rel_phase  <= turn_wrap(start_q - ref_start);
          disc_phase <= turn_wrap(start_q - prev_end);
        end
      end
    end
  end

  // R9: one pulse per interval
  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

  // R9: results hold between pulses
  assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_load |=> ($stable(freq_err) && $stable(rel_phase) && $stable(disc_phase)));

  // R8: a jump is only flagged together with a result
  assert_disc_needs_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disc_vld |-> res_vld);

  // R6: the reference interval reports zero offsets
  assert_first_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !disc_vld) |-> (rel_phase == '0 && disc_phase == '0));

endmodule

// File: tb/tb_slot_phase_fit.sv
module tb_slot_phase_fit;
  localparam int CLK_PERIOD = 10;
  localparam int YW = 20, TW = 12, BF = 16, FREQ_W = YW + BF + 2;
  localparam int GRD = 96;

  logic clk = 1'b0, rst_n = 1'b0, meas_en = 1'b0, half_mode = 1'b0;
  logic smp_vld = 1'b0, slot_strb = 1'b0;
  logic signed [YW-1:0] phase_in = '0;
  logic res_vld, disc_vld;
  logic signed [FREQ_W-1:0] freq_err;
  logic signed [TW-1:0] rel_phase, disc_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_phase_fit dut (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .half_mode(half_mode),
    .smp_vld(smp_vld), .slot_strb(slot_strb), .phase_in(phase_in),
    .res_vld(res_vld), .disc_vld(disc_vld), .freq_err(freq_err),
    .rel_phase(rel_phase), .disc_phase(disc_phase)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // expected per interval
  int e_start[32], e_end[32], e_slope[32], e_edge[32];
  bit e_first[32];
  int n_exp = 0;
  // recorded results
  int r_cyc[32], r_rel[32], r_disc[32];
  longint r_freq[32];
  bit r_dv[32];
  int n_rec = 0;

  always @(negedge clk) begin
    if (res_vld) begin
      if (n_rec < 32) begin
        r_cyc[n_rec]  = cyc;
        r_dv[n_rec]   = disc_vld;
        r_rel[n_rec]  = int'(rel_phase);
        r_disc[n_rec] = int'(disc_phase);
        r_freq[n_rec] = longint'(freq_err);
      end
      n_rec++;
    end
  end

  function automatic int wrap(input int v);
    int m;
    m = ((v % 4096) + 4096) % 4096;
    return (m >= 2048) ? m - 4096 : m;
  endfunction

  function automatic int cdist(input int a, input int b);
    int d;
    d = wrap(a - b);
    return (d < 0) ? -d : d;
  endfunction

  task automatic check(input string rq, input bit ok, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic drive_idle(input int n, input int strb_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld   = 1'b1;
      slot_strb = (strb_every > 0) && (i % strb_every == 0);
      phase_in  = YW'(i * 37);
    end
    @(negedge clk);
    smp_vld = 1'b0; slot_strb = 1'b0;
  endtask

  task automatic drive_interval(input int base, input int slope, input bit half,
                                input bit first, input int gap_every, input bit junk,
                                input int strb_at, input bit flip);
    int len, v;
    len = half ? 1280 : 2560;
    e_start[n_exp] = base;
    e_end[n_exp]   = base + slope * len;
    e_slope[n_exp] = slope;
    e_first[n_exp] = first;
    for (int k = 0; k < len; k++) begin
      if (gap_every > 0 && k % gap_every == 3) begin
        @(negedge clk);
        smp_vld = 1'b0; slot_strb = 1'b1; phase_in = YW'(99999);
      end
      @(negedge clk);
      v = base + slope * k;
      if (junk && (k < GRD || k >= len - GRD)) v = v + 5000 + 17 * k;
      smp_vld   = 1'b1;
      slot_strb = (k == 0 && first) || (k == strb_at);
      half_mode = (flip && k >= 300) ? ~half : half;
      phase_in  = YW'(v);
      if (k == len - GRD - 1) e_edge[n_exp] = cyc + 1;
    end
    n_exp++;
    @(negedge clk);
    smp_vld = 1'b0; slot_strb = 1'b0;
  endtask

  task automatic verify_run(input string name);
    int ref_s, ed, er;
    longint ef;
    ref_s = 0;
    repeat (8) @(negedge clk);
    check("R9", n_rec == n_exp, {name, " result count"}, n_rec, n_exp);
    for (int i = 0; i < n_exp && i < n_rec; i++) begin
      check("R9", r_cyc[i] == e_edge[i] + 3, {name, " result edge"}, r_cyc[i], e_edge[i] + 3);
      ef = longint'(e_slope[i]) * 65536;
      check("R5", (r_freq[i] - ef <= 64) && (ef - r_freq[i] <= 64), {name, " freq_err"}, r_freq[i], ef);
      if (e_first[i]) begin
        ref_s = e_start[i];
        check("R8", r_dv[i] == 1'b0, {name, " disc_vld first"}, r_dv[i], 0);
        check("R6", r_rel[i] == 0 && r_disc[i] == 0, {name, " first rel_phase"}, r_rel[i], 0);
      end else begin
        check("R8", r_dv[i] == 1'b1, {name, " disc_vld"}, r_dv[i], 1);
        ed = wrap(e_start[i] - e_end[i-1]);
        check("R7", cdist(r_disc[i], ed) <= 2, {name, " disc_phase"}, r_disc[i], ed);
        er = wrap(e_start[i] - ref_s);
        check("R6", cdist(r_rel[i], er) <= 2, {name, " rel_phase"}, r_rel[i], er);
      end
    end
    n_exp = 0; n_rec = 0;
  endtask

  task automatic finish_run();
    @(negedge clk);
    meas_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", res_vld == 0 && disc_vld == 0, "valids after reset", {res_vld, disc_vld}, 0);
    check("R1", freq_err == 0, "freq_err after reset", freq_err, 0);
    check("R1", rel_phase == 0 && disc_phase == 0, "phases after reset", rel_phase, 0);
  endtask

  // R2: unstrobed samples before the run are ignored; run starts on strobe
  task automatic t_basic();
    n_exp = 0; n_rec = 0;
    @(negedge clk); meas_en = 1'b1;
    drive_idle(40, 0);
    drive_interval(100, 2, 0, 1, 0, 0, -1, 0);
    drive_interval(5240, -3, 0, 0, 0, 0, -1, 0);
    drive_interval(200, 0, 0, 0, 0, 0, -1, 0);
    verify_run("basic R2");
    finish_run();
  endtask

  // R3: half and full intervals mixed
  task automatic t_half();
    n_exp = 0; n_rec = 0;
    @(negedge clk); meas_en = 1'b1;
    drive_idle(3, 0);
    drive_interval(300, -1, 1, 1, 0, 0, -1, 0);
    drive_interval(1000, 1, 0, 0, 0, 0, -1, 0);
    drive_interval(-2000, 5, 1, 0, 0, 0, -1, 0);
    verify_run("half R3");
    finish_run();
  endtask

  // R4 junk in guards, R2 gaps and stray strobe, R3 half_mode flipped mid-interval
  task automatic t_guard();
    n_exp = 0; n_rec = 0;
    @(negedge clk); meas_en = 1'b1;
    drive_idle(3, 0);
    drive_interval(-400, 3, 0, 1, 7, 1, 700, 1);
    drive_interval(7000, -2, 1, 0, 11, 1, 200, 1);
    verify_run("guard R4");
    finish_run();
  endtask

  // R7 / R6 wrap of large jumps
  task automatic t_wrap();
    n_exp = 0; n_rec = 0;
    @(negedge clk); meas_en = 1'b1;
    drive_idle(3, 0);
    drive_interval(0, 1, 0, 1, 0, 0, -1, 0);
    drive_interval(5560, 0, 0, 0, 0, 0, -1, 0);
    verify_run("wrap R7");
    finish_run();
  endtask

  // R10 disabled block is silent; re-arm gives a new reference
  task automatic t_rearm();
    n_exp = 0; n_rec = 0;
    @(negedge clk); meas_en = 1'b1;
    drive_idle(3, 0);
    drive_interval(50, 1, 0, 1, 0, 0, -1, 0);
    verify_run("rearm first");
    @(negedge clk); meas_en = 1'b0;
    n_rec = 0;
    drive_idle(3000, 500);
    repeat (6) @(negedge clk);
    check("R10", n_rec == 0, "results while disabled", n_rec, 0);
    n_rec = 0;
    @(negedge clk); meas_en = 1'b1;
    drive_idle(5, 0);
    drive_interval(-700, 2, 1, 1, 0, 0, -1, 0);
    drive_interval(-700 + 2 * 1280 + 900, -1, 1, 0, 0, 0, -1, 0);
    verify_run("rearm R10");
    finish_run();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_half();
    t_guard();
    t_wrap();
    t_rearm();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule